// File: doc/BRIEF.md
# Serial Frame-Memory Video Overlay

This block adds a second picture layer to an existing luma video signal. The host fills a small serial non-volatile memory one byte at a time. In write mode the block turns each host byte into eight serial clock pulses on the memory pins. The host itself sends the memory's write command, the address and the data, and it frames the transfer with a chip-select bit in a 4-bit control register. The host never reads the memory back.

In read mode, a frame-start pulse restarts the memory. The block re-selects the device, sends a read command for address 0, and then pulls pixel bits only while the line window and the frame window are both open. It does this on its own, with no further host involvement. The number of bits taken per line and the number of lines taken per frame are both capped by parameters (defaults 640 and 192).

Mode 0 turns every bit into a black or full-scale pixel. Mode 1 pairs the bits into four evenly spaced grey levels. The resulting overlay is merged with the incoming luma by taking the larger of the two values.

Top module: `serial_overlay_video`

## Requirements
- R1: The control register `ctrl[3:0]` is loaded by `reg_we` from `reg_din`. Its fields are as follows. Bit 0 drives `bank_sel`. Bit 1 selects the serial clock source: 1 means host byte writes, 0 means autonomous read streaming. Bit 2 is the memory chip select and drives `mem_cs_n`, where 1 deselects. Bit 3 is the pixel mode: 0 is 1 bit per pixel, 1 is 2 bits per pixel.
- R2: In write mode, each accepted `byte_we` sends `byte_din` MSB first. Each bit is placed on `mem_mosi` while `mem_sclk` is low, then clocked by one rising edge, for 8 rising edges in total, after which `mem_sclk` returns low. A `byte_we` that arrives before the previous byte has finished is dropped.
- R3: A `byte_we` in read mode (bit 1 = 0) causes no serial clock activity. It sets `err`, which stays set until the next `reg_we`. A `reg_we` in the same cycle wins, and `err` reads 0.
- R4: A `frame_start` pulse in read mode forces `mem_cs_n` high for one cycle. The block then sends the 24-bit command made of opcode 0x03 followed by 16-bit address 0, MSB first, and then enters the data phase.
- R5: In the data phase, one bit is sampled on each `mem_sclk` rising edge, at most one bit per two clock cycles. A rising edge happens only in a cycle where `hactive` and `vactive` are both high. Otherwise `mem_sclk` stays low.
- R6: At most `BITS_PER_LINE` bits are taken per `hactive` window. At most `ACTIVE_LINES` lines are taken per frame, where a line is counted at each `hactive` fall during `vactive`.
- R7: In mode 0, a sampled 1 gives overlay luma all-ones and a sampled 0 gives 0.
- R8: In mode 1, two successive bits form one pixel, with the first bit as the MSB. The pixel value v maps to v*(max/3), which is 0, 5, 10 or 15 for 4-bit luma. Pairing restarts at every rising edge of `hactive`.
- R9: `luma_out` is registered and equals max(`base_luma`, overlay). A sampled pixel reaches `luma_out` two clock edges after the edge that samples its last bit. Once the stream is idle outside the window, the overlay is 0 and `luma_out` follows `base_luma`.
- R10: After reset, `ctrl` is 4'b0100. As a result, `mem_cs_n` is 1, `mem_sclk` is 0, `bank_sel` is 0, `err` is 0 and `luma_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, two cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_din | input | 4 | Control register value |
| byte_we | input | 1 | Host byte write strobe |
| byte_din | input | 8 | Host byte to send to the memory |
| frame_start | input | 1 | One-cycle pulse before each frame's active area |
| hactive | input | 1 | Horizontal display window |
| vactive | input | 1 | Vertical display window |
| base_luma | input | LUMA_W | Incoming luma |
| mem_miso | input | 1 | Serial data from the memory |
| mem_sclk | output | 1 | Serial clock to the memory |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_mosi | output | 1 | Serial data to the memory |
| bank_sel | output | 1 | RAM/ROM bank select bit |
| err | output | 1 | Sticky flag for a host write attempted in read mode |
| luma_out | output | LUMA_W | Combined luma |

## Verification
The bench writes random bytes through the serial write path into a behavioural memory. It then streams them back in both pixel modes and predicts every pixel from the stored bits and a random base level. This catches a wrong bit order, a misplaced pixel pairing, or a minimum taken where a maximum is required.

Frames are driven with more lines and longer windows than the caps allow. A design that ignores the per-line or per-frame limits would clock extra bits, or show overlay pixels on the extra line. A second frame in the other mode must show the same leading bits again, so a block that failed to reissue the read command at address 0 would show shifted pixels.

A byte sent while the serializer is still busy must vanish. A byte sent in read mode must raise the error flag and leave the memory pins quiet. A design that queued the busy byte, or clocked the read-mode byte out anyway, would store or emit wrong data.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef struct packed {
    logic mode;      // bit 3: 0 = 1 bit/pixel, 1 = 2 bits/pixel
    logic cs_n;      // bit 2: memory select, 1 = deselected
    logic src_host;  // bit 1: 1 = host byte writes clock the memory
    logic bank;      // bit 0: RAM/ROM bank select
  } ovl_ctrl_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SHIFT,
    ENG_STREAM
  } eng_state_e;

  localparam logic [7:0] RD_OPCODE  = 8'h03;
  localparam logic [3:0] CTRL_RESET = 4'b0100;

endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
  import ovl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [3:0] reg_din,
  input  logic       byte_we,
  output ovl_ctrl_t  ctrl,
  output logic       err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= ovl_ctrl_t'(CTRL_RESET);
      err  <= 1'b0;
    end else if (reg_we) begin
      ctrl <= ovl_ctrl_t'(reg_din);
      err  <= 1'b0;
    end else if (byte_we && !ctrl.src_host) begin
      err <= 1'b1;
    end
  end

  // R3: any control write clears the sticky flag
  p_err_clear_r3: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !err);

  // R3: a byte write in read mode raises the flag
  p_err_set_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_we && !ctrl.src_host && !reg_we) |=> err);

endmodule

// File: rtl/ovl_ser_engine.sv
module ovl_ser_engine
  import ovl_pkg::*;
#(
  parameter int BITS_PER_LINE = 640,
  parameter int ACTIVE_LINES  = 192,
  parameter int ADDR_W        = 16
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_mode,
  input  logic       frame_start,
  input  logic       hactive,
  input  logic       vactive,
  input  logic       wr_go,
  input  logic [7:0] wr_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       restart,
  output logic       samp_valid,
  output logic       samp_bit,
  output logic       line_start,
  output logic       stream_idle
);

  localparam int CMD_W  = 8 + ADDR_W;
  localparam int LEFT_W = $clog2(CMD_W + 1);
  localparam int BC_W   = $clog2(BITS_PER_LINE + 1);
  localparam int LC_W   = $clog2(ACTIVE_LINES + 1);

  eng_state_e        state;
  logic [CMD_W-1:0]  sh;
  logic [LEFT_W-1:0] left;
  logic              ph, is_read, sclk_q, mosi_q, restart_q, hq;
  logic [BC_W-1:0]   bitcnt;
  logic [LC_W-1:0]   linecnt;
  logic              line_end_c, win, sample_now, rd_start;

  assign line_start = hactive & ~hq;
  assign line_end_c = ~hactive & hq;
  assign rd_start   = frame_start & rd_mode;
  assign win        = hactive & vactive & (linecnt < LC_W'(ACTIVE_LINES)) &
                      (line_start | (bitcnt < BC_W'(BITS_PER_LINE)));
  assign sample_now = (state == ENG_STREAM) & rd_mode & ~sclk_q & win;
  assign stream_idle = (state != ENG_STREAM) | (~win & ~sclk_q);

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign restart = restart_q;

  // line and frame budget counters
  always_ff @(posedge clk) begin
    if (rst) begin
      hq      <= 1'b0;
      bitcnt  <= '0;
      linecnt <= '0;
    end else begin
      hq <= hactive;
      if (line_start)
        bitcnt <= sample_now ? BC_W'(1) : '0;
      else if (sample_now)
        bitcnt <= bitcnt + 1'b1;
      if (rd_start)
        linecnt <= '0;
      else if (line_end_c && vactive && (linecnt < LC_W'(ACTIVE_LINES)))
        linecnt <= linecnt + 1'b1;
    end
  end

  // serial state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ENG_IDLE;
      sh         <= '0;
      left       <= '0;
      ph         <= 1'b0;
      is_read    <= 1'b0;
      sclk_q     <= 1'b0;
      mosi_q     <= 1'b0;
      restart_q  <= 1'b0;
      samp_valid <= 1'b0;
      samp_bit   <= 1'b0;
    end else begin
      restart_q  <= rd_start;
      samp_valid <= sample_now;
      samp_bit   <= miso;
      if (rd_start) begin
        state   <= ENG_SHIFT;
        sh      <= {RD_OPCODE, {ADDR_W{1'b0}}};
        left    <= LEFT_W'(CMD_W);
        ph      <= 1'b0;
        is_read <= 1'b1;
        sclk_q  <= 1'b0;
      end else begin
        case (state)
          ENG_IDLE: begin
            sclk_q <= 1'b0;
            if (wr_go) begin
              state   <= ENG_SHIFT;
              sh      <= {wr_byte, {ADDR_W{1'b0}}};
              left    <= LEFT_W'(8);
              ph      <= 1'b0;
              is_read <= 1'b0;
            end
          end
          ENG_SHIFT: begin
            if (is_read != rd_mode) begin
              state  <= ENG_IDLE;
              sclk_q <= 1'b0;
            end else if (!ph) begin
              mosi_q <= sh[CMD_W-1];
              sh     <= sh << 1;
              sclk_q <= 1'b0;
              ph     <= 1'b1;
            end else begin
              sclk_q <= 1'b1;
              ph     <= 1'b0;
              left   <= left - 1'b1;
              if (left == LEFT_W'(1))
                state <= is_read ? ENG_STREAM : ENG_IDLE;
            end
          end
          ENG_STREAM: begin
            if (!rd_mode) begin
              state  <= ENG_IDLE;
              sclk_q <= 1'b0;
            end else if (sclk_q) begin
              sclk_q <= 1'b0;
            end else if (win) begin
              sclk_q <= 1'b1;
            end
          end
          default: begin
            state  <= ENG_IDLE;
            sclk_q <= 1'b0;
          end
        endcase
      end
    end
  end

  // R5: data bits are only taken inside the display window
  p_sample_in_window_r5: assert property (@(posedge clk) disable iff (rst)
    samp_valid |-> $past(hactive && vactive));

  // R5: each serial clock high phase lasts exactly one cycle
  p_sclk_half_rate_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_q) |=> $fell(sclk_q));

  // R6: the per-line budget is never exceeded
  p_line_budget_r6: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= BC_W'(BITS_PER_LINE));

  // R2: output data does not move while the clock is high
  p_mosi_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_SHIFT && sclk_q) |-> $stable(mosi_q));

endmodule

// File: rtl/ovl_pixel_mix.sv
module ovl_pixel_mix #(
  parameter int LUMA_W = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              samp_valid,
  input  logic              samp_bit,
  input  logic              line_start,
  input  logic              stream_idle,
  input  logic [LUMA_W-1:0] base_luma,
  output logic [LUMA_W-1:0] luma_out
);

  localparam logic [LUMA_W-1:0] LMAX = {LUMA_W{1'b1}};
  localparam logic [LUMA_W-1:0] STEP = LMAX / 3;

  logic              pair, hi;
  logic [LUMA_W-1:0] ovl;

  always_ff @(posedge clk) begin
    if (rst) begin
      pair     <= 1'b0;
      hi       <= 1'b0;
      ovl      <= '0;
      luma_out <= '0;
    end else begin
      luma_out <= (ovl > base_luma) ? ovl : base_luma;
      if (line_start)
        pair <= 1'b0;
      else if (samp_valid)
        pair <= ~pair;
      if (samp_valid) begin
        if (!mode)
          ovl <= samp_bit ? LMAX : '0;
        else if (!pair)
          hi <= samp_bit;
        else
          ovl <= LUMA_W'({hi, samp_bit}) * STEP;
      end else if (stream_idle) begin
        ovl <= '0;
      end
    end
  end

  // R9: output never falls below the incoming luma
  p_max_combine_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (luma_out >= $past(base_luma)));

endmodule

// File: rtl/serial_overlay_video.sv
module serial_overlay_video
  import ovl_pkg::*;
#(
  parameter int LUMA_W        = 4,
  parameter int BITS_PER_LINE = 640,
  parameter int ACTIVE_LINES  = 192,
  parameter int ADDR_W        = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_din,
  input  logic              byte_we,
  input  logic [7:0]        byte_din,
  input  logic              frame_start,
  input  logic              hactive,
  input  logic              vactive,
  input  logic [LUMA_W-1:0] base_luma,
  input  logic              mem_miso,
  output logic              mem_sclk,
  output logic              mem_cs_n,
  output logic              mem_mosi,
  output logic              bank_sel,
  output logic              err,
  output logic [LUMA_W-1:0] luma_out
);

  ovl_ctrl_t ctrl;
  logic      restart, samp_valid, samp_bit, line_start, stream_idle;

  ovl_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reg_we  (reg_we),
    .reg_din (reg_din),
    .byte_we (byte_we),
    .ctrl    (ctrl),
    .err     (err)
  );

  ovl_ser_engine #(
    .BITS_PER_LINE (BITS_PER_LINE),
    .ACTIVE_LINES  (ACTIVE_LINES),
    .ADDR_W        (ADDR_W)
  ) u_eng (
    .clk         (clk),
    .rst         (rst),
    .rd_mode     (~ctrl.src_host),
    .frame_start (frame_start),
    .hactive     (hactive),
    .vactive     (vactive),
    .wr_go       (byte_we & ctrl.src_host & ~reg_we),
    .wr_byte     (byte_din),
    .miso        (mem_miso),
    .sclk        (mem_sclk),
    .mosi        (mem_mosi),
    .restart     (restart),
    .samp_valid  (samp_valid),
    .samp_bit    (samp_bit),
    .line_start  (line_start),
    .stream_idle (stream_idle)
  );

  ovl_pixel_mix #(
    .LUMA_W (LUMA_W)
  ) u_mix (
    .clk         (clk),
    .rst         (rst),
    .mode        (ctrl.mode),
    .samp_valid  (samp_valid),
    .samp_bit    (samp_bit),
    .line_start  (line_start),
    .stream_idle (stream_idle),
    .base_luma   (base_luma),
    .luma_out    (luma_out)
  );

  assign mem_cs_n = ctrl.cs_n | restart;
  assign bank_sel = ctrl.bank;

endmodule

// File: tb/serial_overlay_video_tb.sv
module serial_overlay_video_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LW  = 4;
  localparam int BPL = 16;
  localparam int AL  = 2;
  localparam int MB  = 1024;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 0, byte_we = 0, frame_start = 0, hactive = 0, vactive = 0;
  logic [3:0] reg_din = '0;
  logic [7:0] byte_din = '0;
  logic [LW-1:0] base_luma = '0;
  logic mem_miso = 0;
  logic mem_sclk, mem_cs_n, mem_mosi, bank_sel, err;
  logic [LW-1:0] luma_out;

  int total = 0, fails = 0, cyc = 0;

  serial_overlay_video #(.LUMA_W(LW), .BITS_PER_LINE(BPL), .ACTIVE_LINES(AL)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_din(reg_din), .byte_we(byte_we),
    .byte_din(byte_din), .frame_start(frame_start), .hactive(hactive), .vactive(vactive),
    .base_luma(base_luma), .mem_miso(mem_miso), .mem_sclk(mem_sclk), .mem_cs_n(mem_cs_n),
    .mem_mosi(mem_mosi), .bank_sel(bank_sel), .err(err), .luma_out(luma_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural serial memory: opcode, 16-bit address, then bit-addressed data
  logic mbits [0:MB-1];
  int mcnt = 0;
  logic [7:0] mop = '0;
  logic [15:0] maddr = '0;
  always @(posedge mem_cs_n) begin mcnt = 0; mop = '0; maddr = '0; end
  always @(posedge mem_sclk) if (!mem_cs_n) begin
    if (mcnt < 8) mop = {mop[6:0], mem_mosi};
    else if (mcnt < 24) maddr = {maddr[14:0], mem_mosi};
    else if (mop == 8'h02) mbits[(int'(maddr) * 8 + mcnt - 24) % MB] = mem_mosi;
    mcnt++;
  end
  always @(negedge mem_sclk)
    if (!mem_cs_n && mop == 8'h03 && mcnt >= 24)
      mem_miso = mbits[(int'(maddr) * 8 + mcnt - 24) % MB];

  function automatic int mem_byte(input int a);
    int v = 0;
    for (int i = 0; i < 8; i++) v = (v << 1) | int'(mbits[(a * 8 + i) % MB]);
    return v;
  endfunction

  function automatic int lmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // stream monitor and pixel predictor
  int cur_mode = 0, rises = 0, data_cnt = 0, lbit = 0, frame_bits = 0;
  int gap_rise = 0, all_rises = 0;
  bit mon_en = 0, sclk_p = 0, hact_p = 0, prev_b = 0;
  bit d1_v = 0, d2_v = 0;
  int d1_e = 0, d2_e = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    if (d2_v)
      check(luma_out == LW'(d2_e), cur_mode ? "R8/R9 2-bit pixel" : "R7/R9 1-bit pixel",
            int'(luma_out), d2_e);
    d2_v = d1_v; d2_e = d1_e; d1_v = 0;
    if (hactive && !hact_p) lbit = 0;
    if (mem_sclk && !sclk_p) all_rises++;
    if (mem_cs_n) begin
      rises = 0; data_cnt = 0;
    end else if (mem_sclk && !sclk_p && mon_en) begin
      rises++;
      if (rises > 24) begin
        bit b;
        if (!hactive || !vactive) gap_rise++;
        b = mbits[data_cnt % MB];
        if (cur_mode == 0) begin
          d1_v = 1; d1_e = lmax(int'(base_luma), b ? 15 : 0);
        end else if (lbit % 2 == 1) begin
          d1_v = 1; d1_e = lmax(int'(base_luma), (int'(prev_b) * 2 + int'(b)) * 5);
        end
        prev_b = b;
        data_cnt++; lbit++; frame_bits++;
      end
    end
    sclk_p = mem_sclk;
    hact_p = hactive;
  end

  // watchdog
  always @(posedge clk) if (cyc > 20000) begin
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic wr_reg(input logic [3:0] v);
    @(negedge clk); reg_we = 1; reg_din = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); byte_we = 1; byte_din = b;
    @(negedge clk); byte_we = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic run_frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    repeat (60) @(negedge clk);
    check(mop == 8'h03, "R4 read opcode", int'(mop), 3);
    check(maddr == 16'h0, "R4 start address", int'(maddr), 0);
    frame_bits = 0; gap_rise = 0;
    base_luma = LW'($urandom % 16);
    vactive = 1;
    for (int ln = 0; ln < 3; ln++) begin
      @(negedge clk); hactive = 1;
      repeat (25) @(negedge clk);
      if (ln == 2) check(luma_out == base_luma, "R6 line beyond frame cap", int'(luma_out), int'(base_luma));
      repeat (25) @(negedge clk);
      hactive = 0;
      repeat (5) @(negedge clk);
      base_luma = LW'($urandom % 16);
      repeat (3) @(negedge clk);
      check(luma_out == base_luma, "R9 overlay zero outside window", int'(luma_out), int'(base_luma));
      repeat (2) @(negedge clk);
    end
    vactive = 0;
    repeat (5) @(negedge clk);
    check(frame_bits == BPL * AL, "R6 bits per frame", frame_bits, BPL * AL);
    check(gap_rise == 0, "R5 serial clock outside window", gap_rise, 0);
  endtask

  logic [7:0] data [4];

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < MB; i++) mbits[i] = 1'b0;
    repeat (5) @(negedge clk);
    check(mem_cs_n == 1'b1, "R10 reset cs", int'(mem_cs_n), 1);
    check(mem_sclk == 1'b0, "R10 reset sclk", int'(mem_sclk), 0);
    check(err == 1'b0, "R10 reset err", int'(err), 0);
    check(luma_out == '0, "R10 reset luma", int'(luma_out), 0);
    check(bank_sel == 1'b0, "R10 reset bank", int'(bank_sel), 0);
    rst = 0;
    repeat (2) @(negedge clk);

    wr_reg(4'b0101);
    check(bank_sel == 1'b1, "R1 bank bit", int'(bank_sel), 1);
    wr_reg(4'b0010);
    check(mem_cs_n == 1'b0, "R1 select bit", int'(mem_cs_n), 0);

    // fill bytes 0..3 through the write path
    wr_byte(8'h02); wr_byte(8'h00); wr_byte(8'h00);
    for (int i = 0; i < 4; i++) begin
      data[i] = 8'($urandom);
      if (i == 0) data[i] = 8'hA5;
      wr_byte(data[i]);
    end
    check(mop == 8'h02, "R2 write opcode seen", int'(mop), 2);
    wr_reg(4'b0110);
    for (int i = 0; i < 4; i++)
      check(mem_byte(i) == int'(data[i]), "R2 byte stored", mem_byte(i), int'(data[i]));

    // byte offered while busy is dropped
    wr_reg(4'b0010);
    wr_byte(8'h02); wr_byte(8'h00); wr_byte(8'h08);
    @(negedge clk); byte_we = 1; byte_din = 8'h3C;
    @(negedge clk); byte_we = 0;
    repeat (2) @(negedge clk); byte_we = 1; byte_din = 8'hFF;
    @(negedge clk); byte_we = 0;
    repeat (20) @(negedge clk);
    wr_byte(8'h81);
    wr_reg(4'b0110);
    check(mem_byte(8) == 8'h3C, "R2 first byte kept", mem_byte(8), 8'h3C);
    check(mem_byte(9) == 8'h81, "R2 busy byte dropped", mem_byte(9), 8'h81);

    // write attempt in read mode
    wr_reg(4'b0100);
    begin
      int r0;
      r0 = all_rises;
      @(negedge clk); byte_we = 1; byte_din = 8'h55;
      @(negedge clk); byte_we = 0;
      check(err == 1'b1, "R3 error flag set", int'(err), 1);
      repeat (20) @(negedge clk);
      check(all_rises == r0, "R3 no clock on ignored write", all_rises - r0, 0);
      check(err == 1'b1, "R3 error flag sticky", int'(err), 1);
    end
    wr_reg(4'b0100);
    check(err == 1'b0, "R3 error cleared by register write", int'(err), 0);

    // frames in both modes, each restarting from address 0
    mon_en = 1;
    cur_mode = 0;
    wr_reg(4'b0000);
    run_frame();
    cur_mode = 1;
    wr_reg(4'b1000);
    run_frame();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule